// File: doc/BRIEF.md
# Exception vector catch detector

This block watches the instruction fetch stream and raises a debug event when a fetch lands on an exception vector that has its catch enabled. The fetch address is compared with the active vector base. The word offset inside the eight-word vector table then picks a vector slot. A 32-bit catch-enable value supplies one enable bit for each slot and security context. The current security context and the configuration of the highest privilege level decide which group of enable bits applies.

The event is registered. It appears one clock after the matching fetch and lasts one clock. The slot number of the matched vector is given with it. Picking the vector base, stopping the core and writing the enable value are handled elsewhere. The enable value is taken as a plain input.

Top module: `vcatch_detector`

## Requirements
- R1: While `rst` is high at a rising edge, `catch_evt` and `catch_idx` are 0 after that edge.
- R2: A fetch hits slot k (k = 0..7) only when `fetch_valid` is 1 and `fetch_addr` equals `vec_base + 4*k` exactly, computed modulo 2^ADDR_W. A catching hit sets `catch_evt` to 1 for exactly the next cycle, with `catch_idx` = k. Otherwise `catch_evt` is 0 and `catch_idx` is 0.
- R3: Slot 0 (offset 0x00) and slot 5 (offset 0x14) never catch, whatever the enable value holds.
- R4: With `top_cfg` = 1 (highest level present, 32-bit) or 2 (present, 64-bit) and `sec_ctx` = 0 (non-secure), slot k catches when `catch_reg[24+k]` is 1. The slots are 1 undefined instruction, 2 supervisor call, 3 prefetch abort, 4 data abort, 6 IRQ and 7 FIQ.
- R5: With `top_cfg` = 1 or 2 and `sec_ctx` = 1 (secure), slot k catches when `catch_reg[k]` is 1.
- R6: With `top_cfg` = 1 and `sec_ctx` = 2 (monitor mode), slot k catches when `catch_reg[8+k]` is 1, for k in {2,3,4,6,7}. Slot 1 never catches in monitor mode.
- R7: With `top_cfg` = 0 (highest level absent), slot k catches when `catch_reg[k]` is 1, for every value of `sec_ctx`.
- R8: With `top_cfg` = 2 and `sec_ctx` = 2, no fetch catches. With `top_cfg` = 2, bits 8..24 have no effect.
- R9: Bits 0, 5, 8, 9, 13, 16..24 and 29 of `catch_reg` never cause an event.
- R10: A cycle with `fetch_valid` = 0 produces no event in the next cycle, whatever the address.
- R11: `top_cfg` = 3, or `sec_ctx` = 3 with `top_cfg` other than 0, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| vec_base | input | ADDR_W | Active vector table base |
| sec_ctx | input | 2 | 0 non-secure, 1 secure, 2 monitor, 3 invalid |
| top_cfg | input | 2 | 0 absent, 1 present 32-bit, 2 present 64-bit, 3 invalid |
| catch_reg | input | 32 | Catch-enable value |
| catch_evt | output | 1 | One-cycle catch event |
| catch_idx | output | 3 | Slot number of the caught vector, 0 when idle |

## Verification
On every cycle, the assertions check the following. An idle fetch yields no event. The event never names slot 0 or 5, and the slot output is zero whenever no event is present. Monitor context under the 64-bit configuration stays silent, as do invalid codes. An enable value with only reserved bits set never fires. Which enable bit belongs to which slot and context can only be shown by the bench. It sweeps every single enable bit across every slot, context and configuration. It also checks misaligned, out-of-window and wrapped addresses, and back-to-back hits that must give adjacent pulses.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
  localparam int REG_W   = 32;
  localparam int SLOT_W  = 3;
  localparam int NSLOT   = 1 << SLOT_W;
  localparam int OFS_LSB = 2;

  // lane group base positions inside the enable value
  localparam int NS_BASE  = 24;
  localparam int SEC_BASE = 0;
  localparam int MON_BASE = 8;

  // slots that can ever catch, and those valid in monitor context
  localparam logic [NSLOT-1:0] SLOT_USABLE = 8'b1101_1110;
  localparam logic [NSLOT-1:0] MON_USABLE  = 8'b1101_1100;

  typedef enum logic [1:0] {
    CTX_NONSEC = 2'd0,
    CTX_SEC    = 2'd1,
    CTX_MON    = 2'd2,
    CTX_BAD    = 2'd3
  } sec_ctx_t;

  typedef enum logic [1:0] {
    TOP_ABSENT = 2'd0,
    TOP_NARROW = 2'd1,
    TOP_WIDE   = 2'd2,
    TOP_BAD    = 2'd3
  } top_cfg_t;
endpackage

// File: rtl/vcatch_addr_match.sv
module vcatch_addr_match
  import vcatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 fetch_valid,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic [ADDR_W-1:0]    vec_base,
  output logic                 slot_hit,
  output logic [SLOT_W-1:0]    slot_idx
);
  localparam int WIN_W = SLOT_W + OFS_LSB;

  logic [ADDR_W-1:0] delta;
  logic              in_window;
  logic              aligned;

  always_comb begin
    delta     = fetch_addr - vec_base;
    in_window = (delta[ADDR_W-1:WIN_W] == '0);
    aligned   = (delta[OFS_LSB-1:0] == '0);
    slot_hit  = fetch_valid & in_window & aligned;
    slot_idx  = delta[WIN_W-1:OFS_LSB];
  end
endmodule

// File: rtl/vcatch_lane_pick.sv
module vcatch_lane_pick
  import vcatch_pkg::*;
(
  input  logic [REG_W-1:0] catch_reg,
  input  sec_ctx_t         ctx,
  input  top_cfg_t         cfg,
  output logic [NSLOT-1:0] lane_en
);
  logic [NSLOT-1:0] ns_en;
  logic [NSLOT-1:0] sec_en;
  logic [NSLOT-1:0] mon_en;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign ns_en[s]  = SLOT_USABLE[s] & catch_reg[NS_BASE + s];
    assign sec_en[s] = SLOT_USABLE[s] & catch_reg[SEC_BASE + s];
    assign mon_en[s] = MON_USABLE[s]  & catch_reg[MON_BASE + s];
  end

  always_comb begin
    lane_en = '0;
    unique case (cfg)
      TOP_ABSENT: lane_en = sec_en;
      TOP_NARROW: begin
        unique case (ctx)
          CTX_NONSEC: lane_en = ns_en;
          CTX_SEC:    lane_en = sec_en;
          CTX_MON:    lane_en = mon_en;
          default:    lane_en = '0;
        endcase
      end
      TOP_WIDE: begin
        unique case (ctx)
          CTX_NONSEC: lane_en = ns_en;
          CTX_SEC:    lane_en = sec_en;
          default:    lane_en = '0;
        endcase
      end
      default: lane_en = '0;
    endcase
  end
endmodule

// File: rtl/vcatch_event_reg.sv
module vcatch_event_reg
  import vcatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [SLOT_W-1:0] fire_idx,
  output logic              evt_q,
  output logic [SLOT_W-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      idx_q <= '0;
    end else begin
      evt_q <= fire;
      idx_q <= fire ? fire_idx : '0;
    end
  end
endmodule

// File: rtl/vcatch_detector.sv
module vcatch_detector
  import vcatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [ADDR_W-1:0] vec_base,
  input  logic [1:0]        sec_ctx,
  input  logic [1:0]        top_cfg,
  input  logic [31:0]       catch_reg,
  output logic              catch_evt,
  output logic [2:0]        catch_idx
);
  localparam logic [REG_W-1:0] LIVE_MASK = 32'hDE00_DCDE;

  logic              slot_hit;
  logic [SLOT_W-1:0] slot_idx;
  logic [NSLOT-1:0]  lane_en;
  logic              fire;

  vcatch_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .vec_base    (vec_base),
    .slot_hit    (slot_hit),
    .slot_idx    (slot_idx)
  );

  vcatch_lane_pick u_pick (
    .catch_reg (catch_reg),
    .ctx       (sec_ctx_t'(sec_ctx)),
    .cfg       (top_cfg_t'(top_cfg)),
    .lane_en   (lane_en)
  );

  assign fire = slot_hit & lane_en[slot_idx];

  vcatch_event_reg u_evt (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .fire_idx (slot_idx),
    .evt_q    (catch_evt),
    .idx_q    (catch_idx)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!catch_evt && catch_idx == '0));

  // R10
  no_fetch_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !catch_evt);

  // R3
  skip_slots_chk: assert property (@(posedge clk) disable iff (rst)
    catch_evt |-> (catch_idx != 3'd0 && catch_idx != 3'd5));

  // R2
  idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !catch_evt |-> catch_idx == 3'd0);

  // R8
  wide_monitor_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (top_cfg == 2'd2 && sec_ctx == 2'd2) |=> !catch_evt);

  // R11
  bad_code_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (top_cfg == 2'd3 || (top_cfg != 2'd0 && sec_ctx == 2'd3)) |=> !catch_evt);

  // R9
  reserved_only_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((catch_reg & LIVE_MASK) == '0) |=> !catch_evt);
endmodule

// File: tb/tb_vcatch_detector.sv
module tb_vcatch_detector;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] vec_base;
  logic [1:0]    sec_ctx;
  logic [1:0]    top_cfg;
  logic [31:0]   catch_reg;
  logic          catch_evt;
  logic [2:0]    catch_idx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit exp_evt;
  int exp_idx;
  string exp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcatch_detector #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .vec_base(vec_base), .sec_ctx(sec_ctx), .top_cfg(top_cfg),
    .catch_reg(catch_reg), .catch_evt(catch_evt), .catch_idx(catch_idx)
  );

  // behavioural model: returns -1 for no event, else the slot
  function automatic int model(bit v, logic [AW-1:0] a, logic [AW-1:0] b,
                               int ctx, int cfg, logic [31:0] r);
    logic [AW-1:0] d;
    int k, pos;
    if (!v) return -1;
    d = a - b;
    if (d > 28 || (d % 4) != 0) return -1;
    k = int'(d) / 4;
    if (k == 0 || k == 5) return -1;
    pos = -1;
    if (cfg == 0) pos = k;
    else if (cfg == 1 || cfg == 2) begin
      if (ctx == 0) pos = 24 + k;
      else if (ctx == 1) pos = k;
      else if (ctx == 2 && cfg == 1 && k != 1) pos = 8 + k;
    end
    if (pos < 0) return -1;
    return r[pos] ? k : -1;
  endfunction

  function automatic string ctx_tag(int ctx, int cfg);
    if (cfg == 3 || (cfg != 0 && ctx == 3)) return "R11";
    if (cfg == 0) return "R7";
    if (cfg == 2 && ctx == 2) return "R8";
    if (ctx == 0) return "R4";
    if (ctx == 1) return "R5";
    return "R6";
  endfunction

  task automatic step(string tag, bit r, bit v, logic [AW-1:0] a, logic [AW-1:0] b,
                      int ctx, int cfg, logic [31:0] en);
    int m;
    @(negedge clk);
    total++;
    if (catch_evt !== exp_evt || int'(catch_idx) != exp_idx) begin
      bad++;
      $display("FAIL %s: evt=%0b idx=%0d expected evt=%0b idx=%0d",
               exp_tag, catch_evt, catch_idx, exp_evt, exp_idx);
    end
    rst = r; fetch_valid = v; fetch_addr = a; vec_base = b;
    sec_ctx = 2'(ctx); top_cfg = 2'(cfg); catch_reg = en;
    m = r ? -1 : model(v, a, b, ctx, cfg, en);
    exp_evt = (m >= 0);
    exp_idx = (m >= 0) ? m : 0;
    exp_tag = tag;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [AW-1:0] base;
    rst = 1'b1; fetch_valid = 1'b0; fetch_addr = '0; vec_base = '0;
    sec_ctx = '0; top_cfg = '0; catch_reg = '0;
    exp_evt = 0; exp_idx = 0; exp_tag = "R1";

    // R1: reset holds outputs low even with a catching fetch present
    step("R1", 1, 1, 32'h1004, 32'h1000, 1, 1, 32'hFFFF_FFFF);
    step("R1", 1, 1, 32'h1008, 32'h1000, 0, 1, 32'hFFFF_FFFF);
    step("R1", 0, 0, 0, 0, 0, 0, 0);

    // single-bit sweep over every slot, context and configuration (R4..R8, R11)
    base = 32'h8000_0100;
    for (int cfg = 0; cfg < 4; cfg++)
      for (int ctx = 0; ctx < 4; ctx++)
        for (int b = 0; b < 32; b++)
          for (int k = 0; k < 8; k++)
            step(ctx_tag(ctx, cfg), 0, 1, base + 4*k, base, ctx, cfg, 32'h1 << b);

    // R9: only reserved bits set
    for (int cfg = 0; cfg < 4; cfg++)
      for (int ctx = 0; ctx < 4; ctx++)
        for (int k = 0; k < 8; k++)
          step("R9", 0, 1, base + 4*k, base, ctx, cfg, ~32'hDE00_DCDE);

    // R3: slots 0 and 5 with everything enabled
    for (int cfg = 0; cfg < 3; cfg++)
      for (int ctx = 0; ctx < 3; ctx++) begin
        step("R3", 0, 1, base, base, ctx, cfg, 32'hFFFF_FFFF);
        step("R3", 0, 1, base + 20, base, ctx, cfg, 32'hFFFF_FFFF);
      end

    // R10: valid low at matching addresses
    for (int k = 0; k < 8; k++)
      step("R10", 0, 0, base + 4*k, base, 1, 1, 32'hFFFF_FFFF);

    // R2: misaligned, outside the window, below the base, wrap, back-to-back
    for (int o = 1; o < 4; o++)
      step("R2", 0, 1, base + 4 + o, base, 1, 1, 32'hFFFF_FFFF);
    step("R2", 0, 1, base + 32, base, 1, 1, 32'hFFFF_FFFF);
    step("R2", 0, 1, base - 4, base, 1, 1, 32'hFFFF_FFFF);
    step("R2", 0, 1, base + 32'h1000_0004, base, 1, 1, 32'hFFFF_FFFF);
    step("R2", 0, 1, 32'h0000_0008, 32'hFFFF_FFF0, 0, 1, 32'hFFFF_FFFF);
    step("R2", 0, 1, 32'h0000_000C, 32'hFFFF_FFF0, 0, 1, 32'hFFFF_FFFF);
    for (int k = 1; k < 8; k++)
      step("R2", 0, 1, base + 4*k, base, 0, 0, 32'h0000_00FF);
    step("R2", 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0);

    // mixed pseudo-random traffic near the table
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] rb;
      int rc, rf;
      rb = {$urandom} & 32'hFFFF_FF00;
      rc = $urandom_range(0, 3);
      rf = $urandom_range(0, 3);
      step(ctx_tag(rc, rf), ($urandom_range(0, 99) == 0), $urandom_range(0, 3) != 0,
           rb + AW'($urandom_range(0, 40)), rb, rc, rf, $urandom);
    end

    step("R1", 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule